// File: doc/BRIEF.md
# Segmented Program Address Sequencer

This block produces the instruction fetch address for a small 4-bit processor with a 256-word program store. A 4-bit step counter forms the low nibble of the address. A 4-bit page register forms the high nibble. Once per instruction, a fetch strobe copies the combined page and step value into an 8-bit address holding register. That register drives memory for the rest of the instruction.

Control sequencing outside the block raises the step strobe after each executed instruction. It pulls the active-low restart line to send the program back to step zero of the current page. When a conditional jump is taken, it raises the page-load strobe, which copies the accumulator nibble into the page register. Because memory sees only the held address, page and step changes made while an instruction executes do not reach memory until the next fetch. A run-mode input controls an output-enable flag, so an external loader can drive the memory address while the block is idle.

Top module: `prog_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the step counter, the page register and the held address all become zero. `fetch_addr` reads 0x00 after that edge.
- R2: With `restart_n` high and `page_load` low, a high `step_en` at a rising edge adds one to the step counter. The counter goes from 15 to 0.
- R3: A low `restart_n` at a rising edge clears the step counter to zero and leaves the page register unchanged.
- R4: A high `page_load` at a rising edge copies `acc` into the page register and clears the step counter to zero.
- R5: When `step_en` is high in the same cycle as a low `restart_n` or a high `page_load`, the clear wins and the step counter becomes zero.
- R6: A high `fetch_latch` at a rising edge loads `fetch_addr` with {page register, step counter}, using the values those registers held before that edge. Page bits form [7:4] and step bits form [3:0]. With `fetch_latch` low, `fetch_addr` keeps its value.
- R7: A step, restart or page load applied in the same cycle as a fetch capture does not affect the captured address. It appears only at the next capture.
- R8: `addr_oe` is high exactly when `run_n` is low. It follows `run_n` with no clock delay.
- R9: When the step counter wraps from 15 to 0, the page register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the step counter by one |
| restart_n | input | 1 | Clear the step counter, active low |
| page_load | input | 1 | Load the page register from `acc` and clear the step counter |
| acc | input | 4 | Accumulator nibble, the new page value |
| fetch_latch | input | 1 | Capture {page, step} into the held address |
| run_n | input | 1 | Run mode, active low; programming mode when high |
| fetch_addr | output | 8 | Held instruction address |
| addr_oe | output | 1 | High when the held address may drive memory |

## Verification
Two events can land on the same clock edge: the fetch capture and a change to the step counter or page register. In directed cases the bench raises `fetch_latch` together with `step_en`, with a low `restart_n`, and with `page_load`. It then checks that the captured value is the address from before the change, and that the next capture shows the updated address. The clear-versus-step conflict is provoked by pairing `step_en` with each clear source in turn. A seeded random phase then mixes all strobes freely, and the bench compares every cycle against its own reference model.

// File: rtl/pas_pkg.sv
// Package: shared widths and the step-counter command for the address sequencer.
// Assumes: all strobes are synchronous and sampled on the rising clock edge.
package pas_pkg;

    localparam int STEP_W_DEF = 4;
    localparam int PAGE_W_DEF = 4;

    // Command to the step counter, decoded from the control strobes.
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_CLEAR = 2'd1,
        STEP_INC   = 2'd2
    } step_cmd_e;

    // Decode the strobes: both clear sources take priority over stepping.
    function automatic step_cmd_e decode_step(input logic restart_n,
                                              input logic page_load,
                                              input logic step_en);
        if (!restart_n || page_load) return STEP_CLEAR;
        if (step_en)                 return STEP_INC;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/pas_step_counter.sv
// Module: step counter that supplies the low part of the fetch address.
// Does: clears, advances by one with wrap-around, or holds, depending on cmd.
// Assumes: cmd has already been prioritised; rst_n is synchronous, active low.
module pas_step_counter #(
    parameter int STEP_W = pas_pkg::STEP_W_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pas_pkg::step_cmd_e     cmd,
    output logic [STEP_W-1:0]      step_q
);
    import pas_pkg::*;

    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

    // Purpose: apply the reset, clear, increment or hold command each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            unique case (cmd)
                STEP_CLEAR: step_q <= '0;
                STEP_INC:   step_q <= step_q + STEP_ONE;
                default:    step_q <= step_q;
            endcase
        end
    end

    AST_STEP_RESET: assert property (@(posedge clk) !rst_n |=> step_q == '0); // R1
    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == STEP_CLEAR |=> step_q == '0); // R3
    AST_STEP_INC:   assert property (@(posedge clk) disable iff (!rst_n)
        cmd == STEP_INC |=> step_q == $past(step_q) + STEP_ONE); // R2
    AST_STEP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        cmd == STEP_HOLD |=> $stable(step_q)); // R2

endmodule

// File: rtl/pas_page_reg.sv
// Module: page register that supplies the high part of the fetch address.
// Does: loads the accumulator nibble on load_en; otherwise holds its value.
// Assumes: upstream raises load_en only when a conditional jump is taken.
module pas_page_reg #(
    parameter int PAGE_W = pas_pkg::PAGE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [PAGE_W-1:0]   load_val,
    output logic [PAGE_W-1:0]   page_q
);

    // Purpose: capture a new page on load, clear on reset, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (load_en) page_q <= load_val;
    end

    AST_PAGE_RESET: assert property (@(posedge clk) !rst_n |=> page_q == '0); // R1
    AST_PAGE_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> page_q == $past(load_val)); // R4
    AST_PAGE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(page_q)); // R9

endmodule

// File: rtl/pas_addr_hold.sv
// Module: holding register for the fetch address.
// Does: captures the combined page and step value on a capture strobe and
//       keeps it for the whole execution phase.
// Assumes: next_addr carries register outputs, so the value captured is the
//          one from before the same edge.
module pas_addr_hold #(
    parameter int ADDR_W = pas_pkg::STEP_W_DEF + pas_pkg::PAGE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [ADDR_W-1:0]   next_addr,
    output logic [ADDR_W-1:0]   held_addr
);

    // Purpose: load the fetch address on capture, clear on reset, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_addr <= '0;
        else if (capture) held_addr <= next_addr;
    end

    AST_HOLD_RESET:   assert property (@(posedge clk) !rst_n |=> held_addr == '0); // R1
    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> held_addr == $past(next_addr)); // R6
    AST_HOLD_STABLE:  assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held_addr)); // R7

endmodule

// File: rtl/prog_addr_seq.sv
// Module: segmented program address sequencer (top).
// Does: a step counter (low bits) and a page register (high bits) form the
//       next instruction address, and a holding register presents it to
//       program memory from one fetch to the next.
// Assumes: synchronous active-low reset; every strobe is a synchronous enable.
module prog_addr_seq #(
    parameter int STEP_W = pas_pkg::STEP_W_DEF,
    parameter int PAGE_W = pas_pkg::PAGE_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step_en,
    input  logic                        restart_n,
    input  logic                        page_load,
    input  logic [PAGE_W-1:0]           acc,
    input  logic                        fetch_latch,
    input  logic                        run_n,
    output logic [STEP_W+PAGE_W-1:0]    fetch_addr,
    output logic                        addr_oe
);
    import pas_pkg::*;

    localparam int ADDR_W = STEP_W + PAGE_W;

    step_cmd_e           step_cmd;
    logic [STEP_W-1:0]   step_val;
    logic [PAGE_W-1:0]   page_val;
    logic [ADDR_W-1:0]   live_addr;

    // Purpose: turn the control strobes into one prioritised step command.
    always_comb step_cmd = decode_step(restart_n, page_load, step_en);

    // Purpose: combine page (high bits) and step (low bits) into the live address.
    always_comb live_addr = {page_val, step_val};

    // Purpose: let the held address reach memory only while run mode is active.
    always_comb addr_oe = ~run_n;

    pas_step_counter #(.STEP_W(STEP_W)) i_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (step_cmd),
        .step_q (step_val)
    );

    pas_page_reg #(.PAGE_W(PAGE_W)) i_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (page_load),
        .load_val (acc),
        .page_q   (page_val)
    );

    pas_addr_hold #(.ADDR_W(ADDR_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (fetch_latch),
        .next_addr (live_addr),
        .held_addr (fetch_addr)
    );

    AST_CLEAR_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && (!restart_n || page_load)) |=> step_val == '0); // R5
    AST_PAGE_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        page_load |=> step_val == '0); // R4
    AST_WRAP_KEEPS_PAGE:  assert property (@(posedge clk) disable iff (!rst_n)
        (step_cmd == STEP_INC && step_val == '1 && !page_load) |=> $stable(page_val)); // R9

endmodule

// File: tb/test_prog_addr_seq.sv
module test_prog_addr_seq;

    logic       clk = 1'b0;
    logic       rst_n, step_en, restart_n, page_load, fetch_latch, run_n;
    logic [3:0] acc;
    logic [7:0] fetch_addr;
    logic       addr_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic [3:0] m_step, m_page;
    logic [7:0] m_addr;

    always #5 clk = ~clk;

    prog_addr_seq i_prog_addr_seq (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .restart_n(restart_n),
        .page_load(page_load), .acc(acc), .fetch_latch(fetch_latch),
        .run_n(run_n), .fetch_addr(fetch_addr), .addr_oe(addr_oe)
    );

    function automatic logic [3:0] exp_step(logic [3:0] s);
        if (!rst_n) return 4'h0;
        if (!restart_n || page_load) return 4'h0;
        if (step_en) return s + 4'h1;
        return s;
    endfunction

    function automatic logic [3:0] exp_page(logic [3:0] p);
        if (!rst_n) return 4'h0;
        return page_load ? acc : p;
    endfunction

    function automatic logic [7:0] exp_addr(logic [7:0] a, logic [3:0] p, logic [3:0] s);
        if (!rst_n) return 8'h00;
        return fetch_latch ? {p, s} : a;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        rst_n = 1'b1; step_en = 1'b0; restart_n = 1'b1; page_load = 1'b0;
        fetch_latch = 1'b0; acc = 4'h0;
    endtask

    // One clock: update the model from the held inputs, then sample at negedge.
    task automatic tick();
        logic [3:0] s, p;
        logic [7:0] a;
        @(posedge clk);
        s = m_step; p = m_page; a = m_addr;
        m_step = exp_step(s);
        m_page = exp_page(p);
        m_addr = exp_addr(a, p, s);
        @(negedge clk);
        idle();
    endtask

    task automatic fetch_now(string tag, logic [7:0] exp);
        fetch_latch = 1'b1;
        tick();
        chk(tag, fetch_addr, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_step = 4'hx; m_page = 4'hx; m_addr = 8'hxx;
        idle(); run_n = 1'b1;
        rst_n = 1'b0; fetch_latch = 1'b1; page_load = 1'b1; acc = 4'h9;
        @(posedge clk); @(negedge clk);
        m_step = 4'h0; m_page = 4'h0; m_addr = 8'h00;
        idle();
        chk("R1 address after reset", fetch_addr, 8'h00);
        fetch_now("R1 counters after reset", 8'h00);

        // R8: output enable follows run mode without a clock
        run_n = 1'b0; #1; chk("R8 oe in run mode", addr_oe, 1);
        run_n = 1'b1; #1; chk("R8 oe in programming mode", addr_oe, 0);
        run_n = 1'b0;

        // R2: three steps then capture
        repeat (3) begin step_en = 1'b1; tick(); end
        chk("R6 hold while stepping", fetch_addr, 8'h00);
        fetch_now("R2 step by three", 8'h03);

        // R9: page 5, sixteen steps wraps the counter but not the page
        page_load = 1'b1; acc = 4'h5; tick();
        repeat (16) begin step_en = 1'b1; tick(); end
        fetch_now("R9 wrap keeps page", 8'h50);
        repeat (15) begin step_en = 1'b1; tick(); end
        fetch_now("R2 step to 15", 8'h5F);

        // R3: restart clears the step only
        restart_n = 1'b0; tick();
        fetch_now("R3 restart clears step", 8'h50);

        // R4 + R5: page load with step in the same cycle
        step_en = 1'b1; tick(); step_en = 1'b1; tick();
        page_load = 1'b1; acc = 4'hA; step_en = 1'b1; tick();
        fetch_now("R4 R5 page load beats step", 8'hA0);
        step_en = 1'b1; tick();
        restart_n = 1'b0; step_en = 1'b1; tick();
        fetch_now("R5 restart beats step", 8'hA0);

        // R7: changes in the capture cycle show only at the next capture
        step_en = 1'b1; tick(); step_en = 1'b1; tick();
        fetch_latch = 1'b1; step_en = 1'b1; tick();
        chk("R7 capture ignores same-cycle step", fetch_addr, 8'hA2);
        fetch_now("R7 step seen at next capture", 8'hA3);
        fetch_latch = 1'b1; page_load = 1'b1; acc = 4'h3; tick();
        chk("R7 capture ignores same-cycle page load", fetch_addr, 8'hA3);
        fetch_latch = 1'b1; restart_n = 1'b1; step_en = 1'b1; tick();
        chk("R7 page load seen at next capture", fetch_addr, 8'h30);
        fetch_latch = 1'b1; restart_n = 1'b0; tick();
        chk("R7 capture ignores same-cycle restart", fetch_addr, 8'h31);
        fetch_now("R7 restart seen at next capture", 8'h30);

        // Random phase against the model
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            step_en     = ($urandom % 2) == 0;
            restart_n   = ($urandom % 8) != 0;
            page_load   = ($urandom % 6) == 0;
            fetch_latch = ($urandom % 3) == 0;
            acc         = 4'($urandom);
            rst_n       = ($urandom % 97) != 0;
            run_n       = ($urandom % 2) == 0;
            #1; chk("R8 random oe", addr_oe, !run_n);
            tick();
            chk("R6 random address", fetch_addr, m_addr);
        end
        fetch_now("R6 random final state", {m_page, m_step});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule